// File: doc/BRIEF.md
# SPI Register Slave for a Three-Axis Motion Sensor

This block is the host-facing serial port of a small motion sensor. An SPI master reaches a 64-address byte register map through it. The block runs in SPI mode 3: SCLK idles high, the block samples MOSI on the rising edge of SCLK and changes MISO on the falling edge. All three SPI inputs are sampled by the block's own system clock, which must run at least four times faster than SCLK.

A transaction begins when chip select goes low, and the first byte is always a command byte. In the command byte, bit 7 selects the direction (1 = read, 0 = write), bit 6 is the multi-byte flag, and bits 5..0 hold the starting address. Every later byte is either a write taken from MOSI or a read driven on MISO, MSB first. When the multi-byte flag is set, the address moves up by one after each data byte.

The sensor core delivers new X, Y and Z samples with a one-cycle load strobe. The block holds each 16-bit sample as two bytes: the low byte at 0x32, 0x34 or 0x36 and the high byte at the next odd address. Each read command takes a snapshot of all six axis bytes, so a burst read never mixes two different samples.

Top module: `spi_sensor_regs`

## Requirements
- R1: After reset, every writable register reads 0x00, and while chip select is high MISO is driven 0.
- R2: A command byte with bit 7 = 0 writes the following MOSI byte, MSB first, to the addressed register. A command byte with bit 7 = 1 returns the addressed register on MISO, MSB first, with each bit valid before the rising SCLK edge that samples it.
- R3: With the multi-byte flag (command bit 6) set, the address rises by one after every data byte and wraps from 0x3F to 0x00. This applies to both reads and writes.
- R4: With the multi-byte flag clear, only the first data byte is used. Later bytes in the same transaction are not written, read as 0x00, and do not move the address.
- R5: Address 0x00 is read-only and returns the identifier 0xA7. Writes to it have no effect.
- R6: The writable registers are 0x1D..0x2F and 0x31. Addresses 0x01..0x1C, 0x30 and 0x38..0x3F read 0x00, and writes to them have no effect.
- R7: A load strobe captures the X, Y and Z samples. Each sample reads back with its low byte at 0x32, 0x34 or 0x36 and its high byte at 0x33, 0x35 or 0x37 respectively.
- R8: Each read command takes a snapshot of all six axis bytes. Axis reads in that transaction return the snapshot, even if new samples are loaded during the burst.
- R9: If chip select rises in the middle of a byte, the partial byte is dropped. The next transaction starts again with a command byte.
- R10: Writes to the axis addresses 0x32..0x37 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master, 0 when deselected |
| smp_load | input | 1 | One-cycle strobe that captures new samples |
| smp_x | input | 16 | X-axis sample |
| smp_y | input | 16 | Y-axis sample |
| smp_z | input | 16 | Z-axis sample |

## Verification
A fault in the command sequencer shows up within one byte time. A bad address step or a missed skip state returns the neighbouring register on the very next MISO byte, or lets an extra write land that a later read-back reports. A corrupted bit counter shifts every later byte by one or more bit positions, so the next read is visibly misaligned. A stale or torn snapshot only appears as mismatched low and high bytes when new samples arrive during a burst, so the bench loads new samples in the middle of an axis read.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int CMD_RD_BIT = 7;
    localparam int CMD_MB_BIT = 6;

    localparam logic [AW-1:0] ADDR_ID    = 6'h00;
    localparam logic [AW-1:0] AXIS_BASE  = 6'h32;
    localparam logic [AW-1:0] AXIS_LAST  = 6'h37;
    localparam logic [AW-1:0] CFG_LO     = 6'h1D;
    localparam logic [AW-1:0] CFG_HI     = 6'h2F;
    localparam logic [AW-1:0] CFG_FORMAT = 6'h31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_SKIP
    } seq_state_e;

    function automatic logic addr_writable(input logic [AW-1:0] a);
        return ((a >= CFG_LO) && (a <= CFG_HI)) || (a == CFG_FORMAT);
    endfunction

    function automatic logic addr_is_axis(input logic [AW-1:0] a);
        return (a >= AXIS_BASE) && (a <= AXIS_LAST);
    endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_start,
    output logic mosi_s
);
    localparam int NSIG = 3;
    // bit 0 sclk, bit 1 cs_n, bit 2 mosi
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b011;

    typedef struct packed {
        logic [STAGES-1:0][NSIG-1:0] chain;
        logic [NSIG-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [NSIG-1:0] cur;

    always_comb begin
        s_d          = s_q;
        s_d.chain[0] = {mosi, cs_n, sclk};
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{IDLE_LVL}};
            s_q.prev  <= IDLE_LVL;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur       = s_q.chain[STAGES-1];
    assign sclk_rise = cur[0] & ~s_q.prev[0];
    assign sclk_fall = ~cur[0] & s_q.prev[0];
    assign cs_act    = ~cur[1];
    assign cs_start  = ~cur[1] & s_q.prev[1];
    assign mosi_s    = cur[2];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rise,
    input  logic          fall,
    input  logic          mosi_s,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    output logic [DW-1:0] rx_byte,
    output logic          byte_done,
    output logic          miso
);
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] rx;
        logic [DW-1:0] tx;
        logic          miso;
        logic          done;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!active) begin
            s_d.cnt  = '0;
            s_d.tx   = '0;
            s_d.miso = 1'b0;
        end else begin
            if (rise) begin
                s_d.rx = {s_q.rx[DW-2:0], mosi_s};
                if (s_q.cnt == CW'(DW-1)) begin
                    s_d.cnt  = '0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (fall) begin
                s_d.miso = s_q.tx[DW-1];
                s_d.tx   = {s_q.tx[DW-2:0], 1'b0};
            end
            if (load) begin
                s_d.tx = load_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_byte   = s_q.rx;
    assign byte_done = s_q.done;
    assign miso      = s_q.miso;

    // R1: a deselected port keeps MISO low
    a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> !miso);

    // R2: the sequencer reloads the transmit byte only right after a byte boundary
    a_r2_load_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> s_q.done);
endmodule

// File: rtl/spi_axis_regfile.sv
module spi_axis_regfile
    import spi_regmap_pkg::*;
#(
    parameter int          NAXIS  = 3,
    parameter logic [DW-1:0] DEV_ID = 8'hA7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [DW-1:0]             rd_data,
    input  logic                      snap_take,
    input  logic                      smp_load,
    input  logic [NAXIS*2*DW-1:0]     smp_bus
);
    localparam int NREG = 2 ** AW;
    localparam int NAB  = 2 * NAXIS;
    localparam int IW   = $clog2(NAB);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] cfg;
        logic [NAB-1:0][DW-1:0]  live;
        logic [NAB-1:0][DW-1:0]  snap;
    } rf_t;

    rf_t r_d, r_q;
    logic [IW-1:0] axis_idx;

    always_comb begin
        r_d = r_q;
        if (smp_load) begin
            r_d.live = smp_bus;
        end
        if (snap_take) begin
            r_d.snap = r_q.live;
        end
        if (wr_en) begin
            r_d.cfg[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign axis_idx = IW'(rd_addr - AXIS_BASE);

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_ID) begin
            rd_data = DEV_ID;
        end else if (addr_writable(rd_addr)) begin
            rd_data = r_q.cfg[rd_addr];
        end else if (addr_is_axis(rd_addr)) begin
            // the snapshot taken this cycle is forwarded straight from the live copy
            rd_data = snap_take ? r_q.live[axis_idx] : r_q.snap[axis_idx];
        end
    end

    // R8: the snapshot changes only when a read command asks for it
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_take |=> $stable(r_q.snap));

    // R10: the sequencer never aims a write at an axis byte
    a_r10_no_axis_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !addr_is_axis(wr_addr));
endmodule

// File: rtl/spi_sensor_regs.sv
module spi_sensor_regs
    import spi_regmap_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  DEV_ID      = 8'hA7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    input  logic        smp_load,
    input  logic [15:0] smp_x,
    input  logic [15:0] smp_y,
    input  logic [15:0] smp_z
);
    localparam int NAXIS = 3;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic          rd;
        logic          multi;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          sclk_rise, sclk_fall, cs_act, cs_start, mosi_s;
    logic [DW-1:0] rx_byte, rd_data, load_byte;
    logic          byte_done, load, wr_en, snap_take;
    logic [AW-1:0] rd_addr;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (spi_sclk),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cs_act   (cs_act),
        .cs_start (cs_start),
        .mosi_s   (mosi_s)
    );

    spi_byte_shifter #(.DW(DW)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (cs_act),
        .rise     (sclk_rise),
        .fall     (sclk_fall),
        .mosi_s   (mosi_s),
        .load     (load),
        .load_byte(load_byte),
        .rx_byte  (rx_byte),
        .byte_done(byte_done),
        .miso     (spi_miso)
    );

    spi_axis_regfile #(.NAXIS(NAXIS), .DEV_ID(DEV_ID)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (c_q.addr),
        .wr_data  (rx_byte),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .snap_take(snap_take),
        .smp_load (smp_load),
        .smp_bus  ({smp_z, smp_y, smp_x})
    );

    // the command byte names the first read address; afterwards the next one is prefetched
    assign rd_addr = (c_q.st == ST_CMD) ? rx_byte[AW-1:0] : AW'(c_q.addr + 1'b1);

    always_comb begin
        c_d       = c_q;
        wr_en     = 1'b0;
        snap_take = 1'b0;
        load      = 1'b0;
        load_byte = '0;
        if (!cs_act) begin
            c_d.st = ST_IDLE;
        end else if (cs_start) begin
            c_d.st = ST_CMD;
        end else if (byte_done) begin
            unique case (c_q.st)
                ST_CMD: begin
                    c_d.rd    = rx_byte[CMD_RD_BIT];
                    c_d.multi = rx_byte[CMD_MB_BIT];
                    c_d.addr  = rx_byte[AW-1:0];
                    c_d.st    = ST_DATA;
                    load      = 1'b1;
                    if (rx_byte[CMD_RD_BIT]) begin
                        snap_take = 1'b1;
                        load_byte = rd_data;
                    end
                end
                ST_DATA: begin
                    wr_en = !c_q.rd && addr_writable(c_q.addr);
                    load  = 1'b1;
                    if (c_q.multi) begin
                        c_d.addr = AW'(c_q.addr + 1'b1);
                        if (c_q.rd) begin
                            load_byte = rd_data;
                        end
                    end else begin
                        c_d.st = ST_SKIP;
                    end
                end
                ST_SKIP: begin
                    load = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st    <= ST_IDLE;
            c_q.addr  <= '0;
            c_q.rd    <= 1'b0;
            c_q.multi <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    // R3: a burst steps the address by one per data byte
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && cs_act && !cs_start && c_q.st == ST_DATA && c_q.multi)
        |=> (c_q.addr == AW'($past(c_q.addr) + 1'b1)));

    // R4: once a single-byte access is used up, the address stays put
    a_r4_skip_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SKIP) |=> $stable(c_q.addr));

    // R9: writes only land at a completed data byte inside a selected transaction
    a_r9_write_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cs_act && byte_done && c_q.st == ST_DATA));
endmodule

// File: tb/spi_sensor_regs_tb.sv
module spi_sensor_regs_tb_top;
    localparam int         HALF   = 8;
    localparam logic [7:0] ID_EXP = 8'hA7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        smp_load = 1'b0;
    logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0] model [64];
    logic [7:0] smp_cur [6];
    logic [7:0] smp_snap [6];
    logic [7:0] txbuf [64];
    logic [7:0] rxbuf [64];

    always #5 clk = ~clk;

    spi_sensor_regs dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_sclk(sclk),
        .spi_cs_n(cs_n),
        .spi_mosi(mosi),
        .spi_miso(miso),
        .smp_load(smp_load),
        .smp_x   (smp_x),
        .smp_y   (smp_y),
        .smp_z   (smp_z)
    );

    function automatic bit tb_writable(input int a);
        return (a >= 'h1D && a <= 'h2F) || a == 'h31;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        if (a == 0) return ID_EXP;
        if (tb_writable(a)) return model[a];
        if (a >= 'h32 && a <= 'h37) return smp_snap[a - 'h32];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            mosi = tx[i];
            half();
            rx[i] = miso;
            sclk = 1'b1;
            half();
        end
    endtask

    task automatic load_samples(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        @(negedge clk);
        smp_x = x; smp_y = y; smp_z = z;
        smp_load = 1'b1;
        @(negedge clk);
        smp_load = 1'b0;
        smp_cur[0] = x[7:0]; smp_cur[1] = x[15:8];
        smp_cur[2] = y[7:0]; smp_cur[3] = y[15:8];
        smp_cur[4] = z[7:0]; smp_cur[5] = z[15:8];
    endtask

    // one transaction; a read is checked against the model, a write updates the model
    task automatic transact(input string req, input bit rd, input bit mb, input int a,
                            input int n, input bit midload);
        logic [7:0] junk;
        logic [7:0] e [64];
        cs_n = 1'b0;
        half();
        xfer_byte({rd, mb, 6'(a)}, junk);
        if (rd) smp_snap = smp_cur;
        for (int i = 0; i < n; i++) begin
            int ai;
            ai = mb ? ((a + i) % 64) : a;
            e[i] = (mb || i == 0) ? exp_read(ai) : 8'h00;
            xfer_byte(rd ? 8'h00 : txbuf[i], rxbuf[i]);
            if (!rd && (mb || i == 0) && tb_writable(ai)) model[ai] = txbuf[i];
            if (midload && i == 1) load_samples(16'h5A5A, 16'hC3C3, 16'h0F0F);
        end
        half();
        cs_n = 1'b1;
        half(); half();
        if (rd) begin
            for (int i = 0; i < n; i++) chk(req, rxbuf[i], e[i]);
        end
    endtask

    task automatic read_all(input string req);
        transact(req, 1'b1, 1'b1, 0, 64, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin smp_cur[i] = 8'h00; smp_snap[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: idle MISO and reset contents (also covers R5, R6 and empty axis bytes)
        chk("R1", 64'(miso), 64'h0);
        read_all("R1");

        // R5: identifier ignores writes
        txbuf[0] = 8'h55;
        transact("R5", 1'b0, 1'b0, 0, 1, 1'b0);
        transact("R5", 1'b1, 1'b0, 0, 1, 1'b0);

        // R6: reserved addresses stay zero
        txbuf[0] = 8'hFF;
        transact("R6", 1'b0, 1'b0, 'h10, 1, 1'b0);
        transact("R6", 1'b0, 1'b0, 'h30, 1, 1'b0);
        transact("R6", 1'b0, 1'b0, 'h38, 1, 1'b0);
        transact("R6", 1'b1, 1'b0, 'h10, 1, 1'b0);
        transact("R6", 1'b1, 1'b0, 'h30, 1, 1'b0);
        transact("R6", 1'b1, 1'b0, 'h38, 1, 1'b0);

        // R7: axis byte layout
        load_samples(16'h1234, 16'hABCD, 16'h0F0E);
        transact("R7", 1'b1, 1'b1, 'h32, 6, 1'b0);
        chk("R7", {rxbuf[1], rxbuf[0]}, 64'h1234);
        chk("R7", {rxbuf[5], rxbuf[4]}, 64'h0F0E);

        // R10: axis bytes ignore writes
        txbuf[0] = 8'h99;
        transact("R10", 1'b0, 1'b0, 'h32, 1, 1'b0);
        transact("R10", 1'b1, 1'b0, 'h32, 1, 1'b0);

        // R8: a load in mid-burst leaves the returned sample intact
        transact("R8", 1'b1, 1'b1, 'h32, 6, 1'b1);
        chk("R8", {rxbuf[3], rxbuf[2]}, 64'hABCD);
        transact("R8", 1'b1, 1'b1, 'h32, 6, 1'b0);
        chk("R8", {rxbuf[3], rxbuf[2]}, 64'hC3C3);

        // R4: single-byte access ignores extra bytes
        txbuf[0] = 8'h11; txbuf[1] = 8'h22; txbuf[2] = 8'h33;
        transact("R4", 1'b0, 1'b0, 'h1D, 3, 1'b0);
        transact("R4", 1'b1, 1'b0, 'h1D, 3, 1'b0);
        transact("R4", 1'b1, 1'b1, 'h1D, 3, 1'b0);

        // R3: burst crossing the read-only hole at 0x30, then the wrap to 0x00
        txbuf[0] = 8'hA1; txbuf[1] = 8'hB2; txbuf[2] = 8'hC3; txbuf[3] = 8'hD4;
        transact("R3", 1'b0, 1'b1, 'h2E, 4, 1'b0);
        transact("R3", 1'b1, 1'b1, 'h2E, 4, 1'b0);
        transact("R3", 1'b1, 1'b1, 'h3F, 2, 1'b0);

        // R9: chip select lifted mid-byte drops the partial byte
        begin
            logic [7:0] junk;
            cs_n = 1'b0;
            half();
            xfer_byte(8'h60, junk);
            for (int i = 0; i < 4; i++) begin
                sclk = 1'b0; mosi = 1'b1; half();
                sclk = 1'b1; half();
            end
            cs_n = 1'b1;
            half(); half();
        end
        transact("R9", 1'b1, 1'b0, 'h20, 1, 1'b0);

        // R2: random writes and read-backs
        for (int t = 0; t < 40; t++) begin
            int a, n;
            bit mb;
            a  = $urandom % 64;
            n  = 1 + ($urandom % 4);
            mb = 1'($urandom % 2);
            for (int i = 0; i < n; i++) txbuf[i] = 8'($urandom);
            transact("R2", 1'b0, mb, a, n, 1'b0);
            if (t % 20 == 19) read_all("R2");
        end
        for (int t = 0; t < 20; t++) begin
            int a, n;
            bit mb;
            a  = $urandom % 64;
            n  = 1 + ($urandom % 4);
            mb = 1'($urandom % 2);
            transact("R2", 1'b1, mb, a, n, 1'b0);
        end
        chk("R1", 64'(miso), 64'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule